// File: doc/BRIEF.md
# Strobed Parallel I/O Port with Interrupt Request

This block is a byte-wide parallel port that serves either a peripheral or a processor, depending on a static mode input. In input mode, a peripheral places a byte on the data input and pulses a strobe. While the strobe is high, the holding register is loaded. When the strobe falls, the value is held and a service request is raised on an active-low interrupt line. The processor then selects the port to read the byte, and that selection withdraws the request. In output mode, the processor's select loads the holding register, and the data output is always enabled so that a peripheral can read it.

Every control and data input is sampled by a free-running system clock through a synchronizer chain. The level-sensitive holding latch is modelled by reloading the register on each clock cycle while its load enable is high. The three-state buffer is modelled by a plain data output and a separate output-enable flag.

Top module: `strb_port`

## Requirements
- R1: The port counts as selected only when `selLowN` is 0 and `selHigh` is 1. The other three combinations leave it unselected.
- R2: With `outMode` = 1, `dataOutEn` is 1 whether or not the port is selected. The holding register follows `dataIn` on every cycle while the port is selected, and keeps its last value once the port is deselected.
- R3: With `outMode` = 0, `dataOutEn` is 1 exactly while the port is selected. The holding register follows `dataIn` while `strobe` is 1 and keeps its last value after `strobe` falls. `dataOut` always shows the holding register, whatever `dataOutEn` is.
- R4: `clearN` = 0 forces the holding register to zero only while its load enable is inactive. While the load enable is active, the load wins over the clear.
- R5: `clearN` = 0 resets the service request, so `irqN` returns to 1 when the port is not selected. A strobe fall that occurs while `clearN` is 0 does not raise a request.
- R6: A falling edge on `strobe` sets the service request. `irqN` then goes to 0 and stays at 0 until the request is cleared.
- R7: Selecting the port clears the service request. After the port is deselected, `irqN` is 1 unless a new strobe fall has occurred.
- R8: `irqN` is 0 for as long as the port is selected, in either mode.
- R9: If a strobe fall and a selection of the port are seen in the same cycle, the clear wins. After a one-cycle selection, `irqN` is 1.
- R10: With `SYNC_STAGES` = 2, a change on the select inputs reaches `irqN` and `dataOutEn` on the second rising clock edge after the change. A change that is loaded into the holding register, or that sets or clears the service request, appears on the third rising edge.
- R11: While `rstN` is 0, and right after it is released with idle inputs, `dataOut` is 0, `dataOutEn` is 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selLowN | input | 1 | Select line, active low |
| selHigh | input | 1 | Select line, active high |
| outMode | input | 1 | 1 selects output mode, 0 selects input mode |
| strobe | input | 1 | Peripheral strobe; loads in input mode, and its fall raises a request |
| clearN | input | 1 | Active-low clear of the holding register and the service request |
| dataIn | input | DATA_W | Data to the holding register |
| dataOut | output | DATA_W | Holding register contents |
| dataOutEn | output | 1 | Output-buffer enable (models the three-state control) |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with the default `DATA_W` = 8 and `SYNC_STAGES` = 2. With these values the latency counts in R10 can be checked edge by edge, and full byte patterns such as 0xA5 and 0x5A show the data path bit for bit. The two-stage chain also makes it possible to land a strobe fall and a one-cycle select pulse in the same synchronized cycle, which the collision case in R9 needs.

// File: rtl/strb_port_pkg.sv
package strb_port_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic latchLoad;   // holding register is transparent this cycle
    logic latchClear;  // clear request (load has priority)
  } ctrlStrobes_t;

  // Bit positions of the packed control-input synchronizer
  localparam int unsigned CI_SEL_LOW_N = 4;
  localparam int unsigned CI_SEL_HIGH  = 3;
  localparam int unsigned CI_OUT_MODE  = 2;
  localparam int unsigned CI_STROBE    = 1;
  localparam int unsigned CI_CLEAR_N   = 0;
  localparam int unsigned CI_WIDTH     = 5;

  // Idle values seen while in reset: deselected, input mode, strobe low, clear inactive
  localparam logic [CI_WIDTH-1:0] CI_IDLE = 5'b10001;

endpackage

// File: rtl/strb_port_sync.sv
module strb_port_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= RST_VAL;
        else       stg[i] <= d;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= RST_VAL;
        else       stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/strb_port_ctrl.sv
module strb_port_ctrl
  import strb_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         selLowN,
  input  logic         selHigh,
  input  logic         outMode,
  input  logic         strobe,
  input  logic         clearN,
  output ctrlStrobes_t strobes,
  output logic         outEnable,
  output logic         irqN
);

  logic [CI_WIDTH-1:0] ciRaw;
  logic [CI_WIDTH-1:0] ciSync;
  logic selLowNS, selHighS, outModeS, strobeS, clearNS;
  logic strobePrev;
  logic strobeFall;
  logic selected;
  logic srq;

  assign ciRaw[CI_SEL_LOW_N] = selLowN;
  assign ciRaw[CI_SEL_HIGH]  = selHigh;
  assign ciRaw[CI_OUT_MODE]  = outMode;
  assign ciRaw[CI_STROBE]    = strobe;
  assign ciRaw[CI_CLEAR_N]   = clearN;

  strb_port_sync #(
    .W       (CI_WIDTH),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CI_IDLE)
  ) uCtrlSync (
    .clk  (clk),
    .rstN (rstN),
    .d    (ciRaw),
    .q    (ciSync)
  );

  assign selLowNS = ciSync[CI_SEL_LOW_N];
  assign selHighS = ciSync[CI_SEL_HIGH];
  assign outModeS = ciSync[CI_OUT_MODE];
  assign strobeS  = ciSync[CI_STROBE];
  assign clearNS  = ciSync[CI_CLEAR_N];

  // R1: select decode
  assign selected = !selLowNS && selHighS;

  // Strobe falling-edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobeS;
  end
  assign strobeFall = strobePrev && !strobeS;

  // Service-request flop: clear and select win over the strobe set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     srq <= 1'b0;
    else if (!clearNS || selected) srq <= 1'b0;
    else if (strobeFall)           srq <= 1'b1;
  end

  // Mode-dependent load source and buffer policy
  always_comb begin
    strobes.latchLoad  = outModeS ? selected : strobeS;
    strobes.latchClear = !clearNS;
    outEnable          = outModeS || selected;
  end

  assign irqN = !(srq || selected);

  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    selected |=> !srq); // R7

  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (strobeFall && !selected && clearNS) |=> srq); // R6

  AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    !clearNS |=> !srq); // R5

  AST_SRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (srq && clearNS && !selected) |=> srq); // R6

endmodule

// File: rtl/strb_port_dpath.sv
module strb_port_dpath
  import strb_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] latchQ
);

  logic [DATA_W-1:0] dataS;

  // Same depth as the control chain so data and strobe stay aligned
  strb_port_sync #(
    .W       (DATA_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('0)
  ) uDataSync (
    .clk  (clk),
    .rstN (rstN),
    .d    (dataIn),
    .q    (dataS)
  );

  // Transparent-latch emulation: reload every cycle while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   latchQ <= '0;
    else if (strobes.latchLoad)  latchQ <= dataS;
    else if (strobes.latchClear) latchQ <= '0;
  end

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchLoad |=> (latchQ == $past(dataS))); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.latchLoad && strobes.latchClear) |=> (latchQ == '0)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.latchLoad && !strobes.latchClear) |=> $stable(latchQ)); // R3

endmodule

// File: rtl/strb_port.sv
module strb_port
  import strb_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              outMode,
  input  logic              strobe,
  input  logic              clearN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              irqN
);

  ctrlStrobes_t strobes;

  strb_port_ctrl #(
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .selLowN   (selLowN),
    .selHigh   (selHigh),
    .outMode   (outMode),
    .strobe    (strobe),
    .clearN    (clearN),
    .strobes   (strobes),
    .outEnable (dataOutEn),
    .irqN      (irqN)
  );

  strb_port_dpath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .strobes (strobes),
    .latchQ  (dataOut)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (irqN && !dataOutEn && dataOut == '0)); // R11

endmodule

// File: tb/strb_port_test.sv
module strb_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              selLowN, selHigh, outMode, strobe, clearN;
  logic [DATA_W-1:0] dataIn;
  logic [DATA_W-1:0] dataOut;
  logic              dataOutEn, irqN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strb_port #(.DATA_W(DATA_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh),
    .outMode(outMode), .strobe(strobe), .clearN(clearN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .irqN(irqN)
  );

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setIn(logic lowN, logic high, logic mode, logic stb, logic clr,
                       logic [DATA_W-1:0] d);
    @(negedge clk);
    selLowN = lowN; selHigh = high; outMode = mode;
    strobe = stb; clearN = clr; dataIn = d;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    checkEq("R11", "dataOut in reset", dataOut, 0);
    checkEq("R11", "dataOutEn in reset", dataOutEn, 0);
    checkEq("R11", "irqN in reset", irqN, 1);
    @(negedge clk); rstN = 1'b1;
    settle();
    checkEq("R11", "dataOut after reset", dataOut, 0);
    checkEq("R11", "dataOutEn after reset", dataOutEn, 0);
    checkEq("R11", "irqN after reset", irqN, 1);
  endtask

  task automatic testDecode();
    for (int c = 0; c < 4; c++) begin
      logic lowN, high, sel;
      lowN = c[1]; high = c[0];
      sel  = !lowN && high;
      setIn(lowN, high, 1'b0, 1'b0, 1'b1, 8'h00);
      settle();
      checkEq("R1", "dataOutEn decode", dataOutEn, sel);
      checkEq("R8", "irqN decode", irqN, !sel);
    end
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    settle();
  endtask

  task automatic testOutputMode();
    setIn(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h99);
    settle();
    checkEq("R2", "enable while deselected", dataOutEn, 1);
    checkEq("R2", "no load while deselected", dataOut, 8'h00);
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5);
    settle();
    checkEq("R2", "load while selected", dataOut, 8'hA5);
    checkEq("R8", "irqN while selected in output mode", irqN, 0);
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C);
    settle();
    checkEq("R2", "follows while selected", dataOut, 8'h3C);
    setIn(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
    setIn(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F);
    settle();
    checkEq("R2", "hold after deselect", dataOut, 8'h3C);
    checkEq("R2", "enable after deselect", dataOutEn, 1);
  endtask

  task automatic testInputMode();
    setIn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A);
    settle();
    checkEq("R3", "strobe loads", dataOut, 8'h5A);
    checkEq("R3", "disabled while deselected", dataOutEn, 0);
    checkEq("R6", "no request while strobe high", irqN, 1);
    setIn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3);
    settle();
    checkEq("R3", "follows while strobe high", dataOut, 8'hC3);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
    settle();
    checkEq("R3", "hold after strobe fall", dataOut, 8'hC3);
    checkEq("R6", "strobe fall raises request", irqN, 0);
    repeat (5) @(negedge clk);
    checkEq("R6", "request persists", irqN, 0);
    setIn(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
    settle();
    checkEq("R3", "enabled while selected", dataOutEn, 1);
    checkEq("R8", "irqN low while selected", irqN, 0);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
    settle();
    checkEq("R7", "request cleared by select", irqN, 1);
    checkEq("R3", "disabled after deselect", dataOutEn, 0);
  endtask

  task automatic testClear();
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22);
    settle();
    checkEq("R4", "clear with load inactive", dataOut, 8'h00);
    setIn(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77);
    settle();
    checkEq("R4", "load overrides clear", dataOut, 8'h77);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77);
    settle();
    checkEq("R4", "clear after load drops", dataOut, 8'h00);
    checkEq("R5", "fall under clear raises nothing", irqN, 1);
    setIn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h44);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44);
    settle();
    checkEq("R6", "request before clear", irqN, 0);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h44);
    settle();
    checkEq("R5", "clear drops request", irqN, 1);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44);
    settle();
    checkEq("R5", "request stays cleared", irqN, 1);
  endtask

  task automatic testCollision();
    setIn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h66);
    settle();
    setIn(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h66);
    setIn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h66);
    settle();
    checkEq("R9", "select wins over strobe fall", irqN, 1);
  endtask

  task automatic testLatency();
    setIn(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11);
    settle();
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    @(posedge clk); @(negedge clk);
    checkEq("R10", "irqN after one edge", irqN, 1);
    @(posedge clk); @(negedge clk);
    checkEq("R10", "irqN after two edges", irqN, 0);
    settle();
    checkEq("R10", "data before change", dataOut, 8'h11);
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22);
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkEq("R10", "data after two edges", dataOut, 8'h11);
    @(posedge clk); @(negedge clk);
    checkEq("R10", "data after three edges", dataOut, 8'h22);
    setIn(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22);
    settle();
  endtask

  initial begin
    rstN = 1'b0;
    selLowN = 1'b1; selHigh = 1'b0; outMode = 1'b0;
    strobe = 1'b0; clearN = 1'b1; dataIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    testDecode();
    testOutputMode();
    testInputMode();
    testClear();
    testCollision();
    testLatency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule